// File: doc/BRIEF.md
# RGB LED Matrix Row-Scan Driver

This block refreshes a two-half RGB LED matrix that has a 1/16 row scan and one bit per colour. Each pixel is on or off, which gives eight colours. The matrix has an upper half and a lower half. Both halves are driven at the same moment from a single row address. For every row pair the block reads the pixel bits from a frame-memory read port and shifts them into the panel. The upper-half triple and the lower-half triple travel in lockstep, one bit per column of a 128-wide chain. After the shift it blanks the display, pulses the latch, moves the row address to the row it has just loaded and unblanks. While one row is on show, the next row is shifted in behind it.

The shift clock is the system clock divided by `CLK_DIV`, which must be at least 2. Data lines change on the falling shift-clock edge, so the panel samples stable data on the rising edge. The first bit of each row belongs to the rightmost column, so memory is read from column `COLS-1` down to column 0. The frame memory has one cycle of read latency. The block fetches one column ahead so that this latency never stalls the shift.

Top module: `led_matrix_scan`

## Requirements
- R1: While `rst_n` is low, `pnl_blank` is 1, `pnl_latch` and `pnl_sclk` are 0, `pnl_top`, `pnl_bot` and `pnl_row` are 0, and the next read requested is row 0, column `COLS-1`.
- R2: Between two latch pulses, `pnl_sclk` has exactly `COLS` rising edges.
- R3: `pnl_top` and `pnl_bot` change only in a cycle where `pnl_sclk` is 0, so the panel sees each bit stable through the rising edge.
- R4: Bits are shifted with the first one going to column `COLS-1` and the last one to column 0. `mem_rd_data[5:3]` = {red, green, blue} of row r feeds `pnl_top[2:0]`, and `mem_rd_data[2:0]` = {red, green, blue} of row r+`ROWS` feeds `pnl_bot[2:0]`. A 1 lights the LED.
- R5: `pnl_latch` is high for exactly one clock cycle. During that cycle `pnl_blank` is 1 and `pnl_sclk` is 0.
- R6: In the cycle after a latch pulse, `pnl_row` equals the row just loaded. The row is coded in binary with bit 3 as the most significant bit, so 1100 is row 12. `pnl_row` changes only while `pnl_blank` is 1.
- R7: Rows are loaded in the order 0, 1, …, `ROWS-1` and then start again at 0.
- R8: `pnl_blank` stays 1 from reset until the first row has been latched. After that it is 0 whenever `pnl_sclk` is high.
- R9: The `pnl_sclk` rising edges within a row are `CLK_DIV` cycles apart. The latch pulses are `COLS*CLK_DIV+5` cycles apart.
- R10: Each row issues exactly `COLS` single-cycle reads (`mem_rd_en`), all with `mem_row` equal to the row being loaded. No read is issued while `pnl_sclk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rd_en | output | 1 | Frame-memory read strobe |
| mem_row | output | ROW_W (4) | Row of the upper half being fetched |
| mem_col | output | COL_W (7) | Column being fetched |
| mem_rd_data | input | 6 | Upper RGB in [5:3], lower RGB in [2:0], valid one cycle after the read |
| pnl_sclk | output | 1 | Panel shift clock |
| pnl_latch | output | 1 | Panel latch pulse |
| pnl_blank | output | 1 | Panel output blank (1 = dark) |
| pnl_row | output | ROW_W (4) | Row address, bit 3 most significant |
| pnl_top | output | 3 | Upper-half {red, green, blue} data |
| pnl_bot | output | 3 | Lower-half {red, green, blue} data |

## Verification
The bench builds the block with `COLS=128`, `ROWS=16` and `CLK_DIV=3`, so the whole 128-column chain and all sixteen row addresses are exercised. The odd divider gives a shift clock whose high phase is longer than its low phase. This shows that data still moves only on the falling edge and that the prefetched read lands one cycle after its request. The bench includes a panel model that shifts on each rising `pnl_sclk` edge and compares the latched rows with the frame contents. Frames are used where only the rightmost column or only the leftmost column is lit, which shows the bit order. A reset in the middle of a shift confirms the blanked restart at row 0.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

  localparam int unsigned RGB_W = 3;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_PRIME,
    ST_SHIFT,
    ST_BLANK,
    ST_LATCH,
    ST_ROW
  } scan_state_e;

endpackage

// File: rtl/led_scan_timer.sv
module led_scan_timer #(
  parameter int COLS    = 128,
  parameter int CLK_DIV = 2,
  localparam int COL_W  = $clog2(COLS),
  localparam int PH_W   = $clog2(CLK_DIV),
  localparam int HALF   = CLK_DIV / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             run_next,
  output logic             ph_zero,
  output logic             ph_last,
  output logic [COL_W-1:0] col,
  output logic             slot_last,
  output logic             sclk
);

  logic [PH_W-1:0]  ph_q, ph_d;
  logic [COL_W-1:0] col_q, col_d;
  logic             col_en;
  logic             sclk_q, sclk_d;

  always_comb begin
    ph_zero   = (ph_q == '0);
    ph_last   = (ph_q == PH_W'(CLK_DIV - 1));
    slot_last = (col_q == COL_W'(COLS - 1));

    if (!run || ph_last) ph_d = '0;
    else                 ph_d = ph_q + PH_W'(1);

    col_en = !run || ph_last;
    if (!run || slot_last) col_d = '0;
    else                   col_d = col_q + COL_W'(1);

    sclk_d = run_next && (ph_d >= PH_W'(HALF));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      col_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      sclk_q <= sclk_d;
      if (col_en) col_q <= col_d;
    end
  end

  assign col  = col_q;
  assign sclk = sclk_q;

  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ph_last && slot_last) |=> !run); // R2

endmodule

// File: rtl/led_scan_fetch.sv
module led_scan_fetch
  import led_scan_pkg::*;
#(
  parameter int COLS   = 128,
  parameter int ROWS   = 16,
  localparam int COL_W = $clog2(COLS),
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  scan_state_e          state,
  input  logic                 ph_zero,
  input  logic                 ph_last,
  input  logic                 slot_last,
  input  logic [COL_W-1:0]     col,
  input  logic [ROW_W-1:0]     load_row,
  input  logic [2*RGB_W-1:0]   mem_rd_data,
  output logic                 mem_rd_en,
  output logic [ROW_W-1:0]     mem_row,
  output logic [COL_W-1:0]     mem_col,
  output logic [RGB_W-1:0]     pix_top,
  output logic [RGB_W-1:0]     pix_bot
);

  logic                 shifting;
  logic [COL_W-1:0]     nxt_idx;
  logic                 load_en;
  logic [2*RGB_W-1:0]   pix_q, pix_d;

  always_comb begin
    shifting  = (state == ST_SHIFT);
    mem_rd_en = (state == ST_FETCH) || (shifting && ph_zero && !slot_last);
    nxt_idx   = shifting ? (col + COL_W'(1)) : '0;
    mem_col   = COL_W'(COLS - 1) - nxt_idx;
    mem_row   = load_row;
    load_en   = (state == ST_PRIME) || (shifting && ph_last && !slot_last);
    pix_d     = load_en ? mem_rd_data : pix_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_q <= '0;
    else        pix_q <= pix_d;
  end

  assign pix_top = pix_q[2*RGB_W-1:RGB_W];
  assign pix_bot = pix_q[RGB_W-1:0];

  AST_ONE_READ_PER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && shifting) |=> !mem_rd_en); // R10

endmodule

// File: rtl/led_scan_ctrl.sv
module led_scan_ctrl
  import led_scan_pkg::*;
#(
  parameter int ROWS   = 16,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ph_last,
  input  logic             slot_last,
  output scan_state_e      state,
  output scan_state_e      state_next,
  output logic [ROW_W-1:0] load_row,
  output logic [ROW_W-1:0] row_out,
  output logic             latch_out,
  output logic             blank_out
);

  scan_state_e      state_q, state_d;
  logic [ROW_W-1:0] load_row_q, load_row_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             latch_q, latch_d;
  logic             blank_q, blank_d;
  logic             row_adv;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH: state_d = ST_PRIME;
      ST_PRIME: state_d = ST_SHIFT;
      ST_SHIFT: if (ph_last && slot_last) state_d = ST_BLANK;
      ST_BLANK: state_d = ST_LATCH;
      ST_LATCH: state_d = ST_ROW;
      ST_ROW:   state_d = ST_FETCH;
      default:  state_d = ST_FETCH;
    endcase

    row_adv = (state_q == ST_ROW);
    if (!row_adv)                             load_row_d = load_row_q;
    else if (load_row_q == ROW_W'(ROWS - 1))  load_row_d = '0;
    else                                      load_row_d = load_row_q + ROW_W'(1);

    latch_d = (state_d == ST_LATCH);
    row_d   = (state_d == ST_ROW) ? load_row_q : row_q;

    if (state_d == ST_BLANK) blank_d = 1'b1;
    else if (row_adv)        blank_d = 1'b0;
    else                     blank_d = blank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_FETCH;
      load_row_q <= '0;
      row_q      <= '0;
      latch_q    <= 1'b0;
      blank_q    <= 1'b1;
    end else begin
      state_q    <= state_d;
      load_row_q <= load_row_d;
      row_q      <= row_d;
      latch_q    <= latch_d;
      blank_q    <= blank_d;
    end
  end

  assign state      = state_q;
  assign state_next = state_d;
  assign load_row   = load_row_q;
  assign row_out    = row_q;
  assign latch_out  = latch_q;
  assign blank_out  = blank_q;

  AST_LATCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    latch_q |=> !latch_q); // R5
  AST_ROW_MOVE_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_q) |-> blank_q); // R6
  AST_ROW_FOLLOWS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    latch_q |=> (row_q == $past(load_row_q))); // R6

endmodule

// File: rtl/led_matrix_scan.sv
module led_matrix_scan
  import led_scan_pkg::*;
#(
  parameter int COLS    = 128,
  parameter int ROWS    = 16,
  parameter int CLK_DIV = 2,
  localparam int COL_W  = $clog2(COLS),
  localparam int ROW_W  = $clog2(ROWS)
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               mem_rd_en,
  output logic [ROW_W-1:0]   mem_row,
  output logic [COL_W-1:0]   mem_col,
  input  logic [2*RGB_W-1:0] mem_rd_data,
  output logic               pnl_sclk,
  output logic               pnl_latch,
  output logic               pnl_blank,
  output logic [ROW_W-1:0]   pnl_row,
  output logic [RGB_W-1:0]   pnl_top,
  output logic [RGB_W-1:0]   pnl_bot
);

  scan_state_e      state, state_next;
  logic             ph_zero, ph_last, slot_last;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] load_row;
  logic             run, run_next;

  assign run      = (state == ST_SHIFT);
  assign run_next = (state_next == ST_SHIFT);

  led_scan_ctrl #(.ROWS(ROWS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ph_last    (ph_last),
    .slot_last  (slot_last),
    .state      (state),
    .state_next (state_next),
    .load_row   (load_row),
    .row_out    (pnl_row),
    .latch_out  (pnl_latch),
    .blank_out  (pnl_blank)
  );

  led_scan_timer #(.COLS(COLS), .CLK_DIV(CLK_DIV)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .run_next  (run_next),
    .ph_zero   (ph_zero),
    .ph_last   (ph_last),
    .col       (col),
    .slot_last (slot_last),
    .sclk      (pnl_sclk)
  );

  led_scan_fetch #(.COLS(COLS), .ROWS(ROWS)) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .ph_zero     (ph_zero),
    .ph_last     (ph_last),
    .slot_last   (slot_last),
    .col         (col),
    .load_row    (load_row),
    .mem_rd_data (mem_rd_data),
    .mem_rd_en   (mem_rd_en),
    .mem_row     (mem_row),
    .mem_col     (mem_col),
    .pix_top     (pnl_top),
    .pix_bot     (pnl_bot)
  );

  AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pnl_latch |-> (pnl_blank && !pnl_sclk)); // R5
  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({pnl_top, pnl_bot}) |-> !pnl_sclk); // R3
  AST_NO_READ_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !pnl_sclk); // R10

endmodule

// File: tb/led_matrix_scan_bench.sv
module led_matrix_scan_bench;

  localparam int COLS = 128;
  localparam int ROWS = 16;
  localparam int DIV  = 3;
  localparam int ROW_PERIOD = COLS * DIV + 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mem_rd_en;
  logic [3:0] mem_row;
  logic [6:0] mem_col;
  logic [5:0] mem_rd_data = '0;
  logic       pnl_sclk, pnl_latch, pnl_blank;
  logic [3:0] pnl_row;
  logic [2:0] pnl_top, pnl_bot;

  int n_chk = 0;
  int n_bad = 0;
  int pat = 4;
  int frames = 0;

  always #2 clk = ~clk;

  led_matrix_scan #(.COLS(COLS), .ROWS(ROWS), .CLK_DIV(DIV)) u_led_matrix_scan (
    .clk(clk), .rst_n(rst_n), .mem_rd_en(mem_rd_en), .mem_row(mem_row),
    .mem_col(mem_col), .mem_rd_data(mem_rd_data), .pnl_sclk(pnl_sclk),
    .pnl_latch(pnl_latch), .pnl_blank(pnl_blank), .pnl_row(pnl_row),
    .pnl_top(pnl_top), .pnl_bot(pnl_bot)
  );

  // Frame content: bit 5..3 = upper {R,G,B} of row r, bit 2..0 = lower of row r+ROWS
  function automatic logic [5:0] pix(int p, int r, int c);
    logic [5:0] v;
    for (int k = 0; k < 6; k++) begin
      int rr;
      rr = (k >= 3) ? r : r + ROWS;
      case (p)
        0:       v[k] = 1'b0;
        1:       v[k] = 1'b1;
        2:       v[k] = (c == COLS - 1);
        3:       v[k] = (c == 0);
        4:       v[k] = (((rr * 5 + c * 3 + k * 7) % 4) == 1);
        default: v[k] = (((rr + c + k) % 2) == 0);
      endcase
    end
    return v;
  endfunction

  always @(posedge clk)
    if (mem_rd_en) mem_rd_data <= pix(pat, int'(mem_row), int'(mem_col));

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Panel model and protocol monitor
  logic [COLS-1:0] sh [6];
  logic       prev_sclk, prev_latch;
  logic [5:0] prev_data;
  logic [3:0] prev_row;
  int cyc, last_rise, last_latch, rise_cnt, rd_cnt, exp_row;
  int v_data, v_period, v_blank, v_row, v_rd;
  bit first_latch, have_latch, after_latch;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) sh[i] = '0;
      prev_sclk = 0; prev_latch = 0; prev_data = '0; prev_row = '0;
      cyc = 0; last_rise = 0; last_latch = 0; rise_cnt = 0; rd_cnt = 0; exp_row = 0;
      v_data = 0; v_period = 0; v_blank = 0; v_row = 0; v_rd = 0;
      first_latch = 0; have_latch = 0; after_latch = 0;
    end else begin
      logic [5:0] d;
      d = {pnl_top, pnl_bot};
      cyc++;
      if (after_latch) begin
        after_latch = 0;
        chk("R5", "latch width", 128'(pnl_latch), 128'(0));
        chk("R6", "row after latch", 128'(pnl_row), 128'(exp_row));
        chk("R6", "blank at row update", 128'(pnl_blank), 128'(1));
        if (exp_row == ROWS - 1) begin
          exp_row = 0;
          frames++;
        end else exp_row++;
      end
      if (d != prev_data && pnl_sclk) v_data++;
      if (pnl_sclk && !prev_sclk) begin
        if (rise_cnt > 0 && cyc - last_rise != DIV) v_period++;
        last_rise = cyc;
        rise_cnt++;
        for (int i = 0; i < 6; i++) sh[i] = {sh[i][COLS-2:0], d[i]};
      end
      if (!first_latch && !pnl_blank) v_blank++;
      if (first_latch && pnl_sclk && pnl_blank) v_blank++;
      if (pnl_row != prev_row && !pnl_blank) v_row++;
      if (mem_rd_en) begin
        rd_cnt++;
        if (int'(mem_row) != exp_row) v_rd++;
      end
      if (pnl_latch) begin
        chk("R5", "blank and sclk at latch", 128'({pnl_blank, pnl_sclk}), 128'(2'b10));
        chk("R2", "rising edges per row", 128'(rise_cnt), 128'(COLS));
        chk("R10", "reads per row", 128'(rd_cnt), 128'(COLS));
        chk("R10", "read row mismatches", 128'(v_rd), 128'(0));
        chk("R3", "data changes with sclk high", 128'(v_data), 128'(0));
        chk("R9", "sclk period errors", 128'(v_period), 128'(0));
        chk("R8", "blank errors", 128'(v_blank), 128'(0));
        chk("R6", "row changes unblanked", 128'(v_row), 128'(0));
        if (have_latch)
          chk("R9", "latch spacing", 128'(cyc - last_latch), 128'(ROW_PERIOD));
        for (int i = 0; i < 6; i++) begin
          logic [COLS-1:0] ev;
          for (int c = 0; c < COLS; c++) begin
            logic [5:0] pv;
            pv = pix(pat, exp_row, c);
            ev[c] = pv[i];
          end
          chk("R4", $sformatf("row %0d line %0d", exp_row, i), 128'(sh[i]), 128'(ev));
        end
        last_latch = cyc; have_latch = 1; first_latch = 1; after_latch = 1;
        rise_cnt = 0; rd_cnt = 0; v_data = 0; v_period = 0; v_blank = 0; v_row = 0; v_rd = 0;
      end
      prev_sclk = pnl_sclk; prev_latch = pnl_latch; prev_data = d; prev_row = pnl_row;
    end
  end

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "blank in reset", 128'(pnl_blank), 128'(1));
    chk("R1", "latch in reset", 128'(pnl_latch), 128'(0));
    chk("R1", "sclk in reset", 128'(pnl_sclk), 128'(0));
    chk("R1", "data in reset", 128'({pnl_top, pnl_bot}), 128'(0));
    chk("R1", "row in reset", 128'(pnl_row), 128'(0));
    rst_n = 1'b1;
    #1;
    chk("R1", "first read strobe", 128'(mem_rd_en), 128'(1));
    chk("R1", "first read column", 128'(mem_col), 128'(COLS - 1));
    chk("R1", "first read row", 128'(mem_row), 128'(0));
  endtask

  task automatic t_frame(input int p);
    int f0;
    f0 = frames;
    wait (frames != f0);
    pat = p;
    chk("R7", "row at frame wrap", 128'(pnl_row), 128'(ROWS - 1));
    f0 = frames;
    wait (frames != f0);
    chk("R7", "row at frame end", 128'(pnl_row), 128'(ROWS - 1));
  endtask

  task automatic t_midreset();
    repeat (1000) @(negedge clk);
    chk("R8", "blank low while shifting", 128'(pnl_blank), 128'(0));
    t_reset();
    t_frame(4);
  endtask

  initial begin
    bit timed_out;
    timed_out = 0;
    fork
      begin
        t_reset();
        t_frame(2);
        t_frame(3);
        t_frame(1);
        t_frame(0);
        t_frame(5);
        t_midreset();
      end
      begin
        repeat (190000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_bad++;
      $display("FAIL R9 watchdog: actual 190000 cycles expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule